// File: doc/BRIEF.md
# Four-Lane Serial Dot-Product Unit with Coefficient Stack

This block produces one component of a 4x4 matrix-by-vector transform. It holds one matrix row as four signed fixed-point coefficients, one per lane. It accepts a four-component signed vector and returns the exact dot product of the row with that vector. Each of the four identical lanes multiplies its coefficient by its vector component using shift-and-add. A multiplicand register shifts toward the MSB and a multiplier register shifts toward the LSB. The lane adds one partial product per cycle to an accumulator, working on magnitudes, and applies the sign at the end. When all lanes are done, the four products are summed in a fixed order into a result wide enough that it cannot overflow.

Each lane keeps its current coefficient on top of a small last-in first-out stack. A push saves all four current coefficients, which stay current. A pop restores the most recently saved row. This lets a transform be kept across a nested drawing routine and brought back afterwards. An illegal stack command sets a sticky error flag and changes nothing.

The vector input and the result output are valid/ready streams. A vector is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been taken, so back-pressure on the output also stalls the input. A result is offered with `out_valid` and held unchanged until `out_ready` is high on a clock edge. The coefficient load and the push/pop commands are plain single-cycle controls and are accepted in any cycle, including while a multiply is running.

Top module: `dotp4_stack`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `err` is 0, all four coefficients are 0 and the stack holds no saved rows.
- R2: The result is the exact signed sum c0*x0 + c1*x1 + c2*x2 + c3*x3 in two's complement, `out_data` being 2*W+2 bits wide. Vector component i sits at `in_vec[i*W +: W]` and coefficient i belongs to lane i. The sum is formed as ((p0+p1)+p2)+p3.
- R3: Every pair of W-bit signed operands is multiplied exactly, including products with -2^(W-1) on either or both sides and products with zero.
- R4: `out_valid` rises exactly W+1 clock cycles after the edge that accepts a vector.
- R5: `in_ready` is low from the accepting edge until the edge where the result is taken. No vector is accepted during that time, whatever `in_valid` and `in_vec` do. `in_ready` is high again in the cycle after the result is taken.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: A cycle with `coef_we` high writes `coef_data` into the current coefficient of lane `coef_sel` (0..3). The multiply uses the coefficients present at the accepting edge, so a write during a multiply does not change that result.
- R8: `push` saves the four current coefficients as one stack entry and leaves them current. `pop` makes the most recently saved entry current and removes it. Up to DEPTH entries are held in last-in first-out order.
- R9: A `push` while DEPTH entries are held, or a `pop` while none are held, sets `err` and leaves the stack and all coefficients unchanged. `err` stays set until reset.
- R10: `push` and `pop` in the same cycle is illegal and is handled as in R9. With `push`, a `coef_we` in the same cycle saves the old value and then makes the written value current. With `pop`, or with an illegal command, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Vector offered |
| in_ready | output | 1 | Block can take a vector |
| in_vec | input | 4*W | Four signed components, component i at bits i*W +: W |
| coef_we | input | 1 | Write one current coefficient this cycle |
| coef_sel | input | 2 | Lane whose coefficient is written |
| coef_data | input | W | Signed coefficient value |
| push | input | 1 | Save the current row on the stack |
| pop | input | 1 | Restore the most recently saved row |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2*W+2 | Signed dot product |
| err | output | 1 | Sticky stack misuse flag |

## Verification
The bench builds the block with W=8 and DEPTH=3. An 8-bit operand makes the serial latency 9 cycles and keeps the exact results easy to compute in the bench. It also puts the most negative operand, -128, on every lane, so the largest magnitude sum can be reached. A three-entry stack can be filled with a few pushes, so overflow, underflow and restoring from a full stack are all tested, along with push and pop mixed with writes in the same cycle. A second reset in the middle of the run lets the error flag be seen rising from zero more than once.

// File: rtl/dotp4_pkg.sv
package dotp4_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SUM  = 2'd2,
    ST_HOLD = 2'd3
  } dp_state_e;
endpackage

// File: rtl/dotp_ctrl.sv
module dotp_ctrl #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic start,
  output logic step,
  output logic load_sum,
  output logic out_valid
);
  import dotp4_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dp_state_e state;
  logic [CW-1:0] cnt;

  assign in_ready  = (state == ST_IDLE);
  assign start     = in_ready && in_valid;
  assign step      = (state == ST_MUL);
  assign load_sum  = (state == ST_SUM);
  assign out_valid = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_MUL;
          cnt   <= '0;
        end
        ST_MUL: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_SUM;
        end
        ST_SUM:  state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_stack.sv
module lane_stack #(
  parameter int W     = 20,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cur,
  output logic         bad_op
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_dn;

  assign sp_dn  = sp - 1'b1;
  assign bad_op = (push && pop)
                || (push && (sp == SPW'(DEPTH)))
                || (pop && (sp == '0));

  always_ff @(posedge clk) begin
    if (push && !bad_op) mem[sp[IW-1:0]] <= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      sp  <= '0;
    end else if (!bad_op) begin
      if (push) begin
        sp <= sp + 1'b1;
        if (wr) cur <= wdata;
      end else if (pop) begin
        cur <= mem[sp_dn[IW-1:0]];
        sp  <= sp_dn;
      end else if (wr) begin
        cur <= wdata;
      end
    end
  end
endmodule

// File: rtl/dotp_lane.sv
module dotp_lane #(
  parameter int W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  step,
  input  logic [W-1:0]          coef,
  input  logic [W-1:0]          xin,
  output logic signed [2*W-1:0] prod
);
  logic [2*W-1:0] up_q;
  logic [W-1:0]   dn_q;
  logic [2*W-1:0] acc_q;
  logic           neg_q;

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  assign prod = neg_q ? $signed(~acc_q + 1'b1) : $signed(acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      dn_q  <= '0;
      acc_q <= '0;
      neg_q <= 1'b0;
    end else if (start) begin
      up_q  <= {{W{1'b0}}, mag(coef)};
      dn_q  <= mag(xin);
      acc_q <= '0;
      neg_q <= coef[W-1] ^ xin[W-1];
    end else if (step) begin
      if (dn_q[0]) acc_q <= acc_q + up_q;
      up_q <= up_q << 1;
      dn_q <= dn_q >> 1;
    end
  end
endmodule

// File: rtl/dotp4_stack.sv
module dotp4_stack #(
  parameter  int W     = 20,
  parameter  int DEPTH = 9,
  localparam int OW    = 2*W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4*W-1:0]  in_vec,
  input  logic            coef_we,
  input  logic [1:0]      coef_sel,
  input  logic [W-1:0]    coef_data,
  input  logic            push,
  input  logic            pop,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   out_data,
  output logic            err
);
  import dotp4_pkg::*;

  logic start, step, load_sum;
  logic signed [2*W-1:0] prod [LANES];
  logic signed [OW-1:0]  ext  [LANES];
  logic [LANES-1:0]      bad;
  logic signed [OW-1:0]  total;

  dotp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .start(start), .step(step), .load_sum(load_sum),
    .out_valid(out_valid)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] cur;

    lane_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .wr(coef_we && (coef_sel == 2'(i))), .wdata(coef_data),
      .cur(cur), .bad_op(bad[i])
    );

    dotp_lane #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .coef(cur), .xin(in_vec[i*W +: W]), .prod(prod[i])
    );

    assign ext[i] = {{2{prod[i][2*W-1]}}, prod[i]};
  end

  assign total = ((ext[0] + ext[1]) + ext[2]) + ext[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      err      <= 1'b0;
    end else begin
      if (load_sum) out_data <= total;
      if (|bad) err <= 1'b1;
    end
  end
endmodule

// File: rtl/dotp4_stack_chk.sv
module dotp4_stack_chk #(
  parameter int W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2*W+1:0]  out_data,
  input logic            err
);
  logic [15:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (in_valid && in_ready) lat <= '0;
    else if (!out_valid) lat <= lat + 1'b1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == 16'(W + 1))); // R4

  AST_NO_READY_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R5

  AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

bind dotp4_stack dotp4_stack_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err(err)
);

// File: tb/sim_dotp4_stack.sv
module sim_dotp4_stack;
  localparam int BW = 8;
  localparam int BD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*BW-1:0] in_vec = '0;
  logic coef_we = 1'b0;
  logic [1:0] coef_sel = '0;
  logic [BW-1:0] coef_data = '0;
  logic push = 1'b0;
  logic pop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2*BW+1:0] out_data;
  logic err;

  always #2 clk = ~clk;

  dotp4_stack #(.W(BW), .DEPTH(BD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_data(coef_data), .push(push), .pop(pop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err(err)
  );

  int total = 0;
  int fails = 0;
  longint expq[$];
  int cm [4];
  int stk [BD][4];
  int sp_m = 0;
  bit err_m = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 0; push = 0; pop = 0; coef_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < 4; l++) cm[l] = 0;
    sp_m = 0; err_m = 0;
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(err == 1'b0, "R1 err after reset", err, 0);
  endtask

  // one command cycle; model follows R8/R9/R10
  task automatic op(input bit pu, input bit po, input bit we, input int lane,
                    input int val, input string req);
    bit ill;
    @(negedge clk);
    push = pu; pop = po; coef_we = we; coef_sel = lane[1:0]; coef_data = val[BW-1:0];
    ill = (pu && po) || (pu && sp_m == BD) || (po && sp_m == 0);
    if (ill) err_m = 1'b1;
    else if (pu) begin
      for (int l = 0; l < 4; l++) stk[sp_m][l] = cm[l];
      sp_m++;
      if (we) cm[lane] = val;
    end else if (po) begin
      sp_m--;
      for (int l = 0; l < 4; l++) cm[l] = stk[sp_m][l];
    end else if (we) cm[lane] = val;
    @(negedge clk);
    push = 0; pop = 0; coef_we = 0;
    chk(err == err_m, req, err, err_m);
  endtask

  task automatic load_row(input int a, input int b, input int c, input int d);
    op(0, 0, 1, 0, a, "R7 load");
    op(0, 0, 1, 1, b, "R7 load");
    op(0, 0, 1, 2, c, "R7 load");
    op(0, 0, 1, 3, d, "R7 load");
  endtask

  task automatic send(input int x0, input int x1, input int x2, input int x3,
                      input bit midload, input int mval);
    longint e;
    int n;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_vec = {x3[BW-1:0], x2[BW-1:0], x1[BW-1:0], x0[BW-1:0]};
    in_valid = 1'b1;
    e = longint'(cm[0]) * x0 + longint'(cm[1]) * x1
      + longint'(cm[2]) * x2 + longint'(cm[3]) * x3;
    expq.push_back(e);
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      if (out_valid) break;
      chk(in_ready == 1'b0, "R5 in_ready low while busy", in_ready, 0);
      in_vec = ~in_vec;          // junk offered while busy: must be ignored
      if (midload && n == 3) begin
        coef_we = 1'b1; coef_sel = 2'd0; coef_data = mval[BW-1:0];
        cm[0] = mval;            // R7: applies only to later vectors
      end
      if (midload && n == 4) coef_we = 1'b0;
      n++;
    end
    in_valid = 1'b0;
    chk(n == BW + 1, "R4 latency", n, BW + 1);
  endtask

  // back-pressure pattern on the output
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1;
      k++;
      out_ready = ((k % 5) != 1) && ((k % 7) != 3) && ((k % 11) != 6);
    end
  end

  // monitor / scoreboard
  bit hold_prev = 1'b0;
  logic [2*BW+1:0] hold_data = '0;
  always @(negedge clk) begin
    if (!rst_n) hold_prev = 1'b0;
    else begin
      if (hold_prev)
        chk(out_valid && (out_data == hold_data), "R6 output held under back-pressure",
            longint'($signed(out_data)), longint'($signed(hold_data)));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R2 unexpected result", longint'($signed(out_data)), 0);
        else begin
          longint e;
          e = expq.pop_front();
          chk(longint'($signed(out_data)) == e, "R2/R3 dot product", longint'($signed(out_data)), e);
        end
      end
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
    end
  end

  task automatic drain();
    int t = 0;
    while ((expq.size() != 0 || !in_ready) && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1: coefficients zero after reset
    send(5, -7, 100, -128, 0, 0);
    // R2 basic patterns
    load_row(3, -5, 7, -128);
    send(1, 1, 1, 1, 0, 0);
    send(127, -1, 0, 55, 0, 0);
    send(-2, 9, -100, 1, 0, 0);
    // R3 extremes
    load_row(-128, -128, -128, -128);
    send(-128, -128, -128, -128, 0, 0);
    send(127, 0, -1, 1, 0, 0);
    load_row(127, 127, -1, 0);
    send(-128, 127, -128, 99, 0, 0);
    // R7 write during a multiply does not affect it
    send(10, 20, 30, 40, 1, -77);
    send(10, 20, 30, 40, 0, 0);
    drain();
    // R8 stack save/restore
    load_row(1, 2, 3, 4);
    op(1, 0, 0, 0, 0, "R8 push");
    load_row(-9, 8, -7, 6);
    send(3, 3, -3, 2, 0, 0);
    op(1, 0, 0, 0, 0, "R8 push");
    load_row(50, -60, 70, -80);
    send(1, 2, 3, 4, 0, 0);
    op(0, 1, 0, 0, 0, "R8 pop restores second row");
    send(1, 2, 3, 4, 0, 0);
    op(0, 1, 0, 0, 0, "R8 pop restores first row");
    send(1, 2, 3, 4, 0, 0);
    // R10 push with write, pop with write
    op(1, 0, 1, 2, 33, "R10 push with write");
    send(0, 0, 1, 0, 0, 0);
    op(0, 1, 1, 1, -44, "R10 pop drops write");
    send(1, 1, 1, 1, 0, 0);
    drain();
    // R10 push and pop together: error, no change
    op(1, 0, 0, 0, 0, "R8 push");
    op(1, 1, 1, 0, 99, "R10 push+pop is an error");
    send(1, 1, 1, 1, 0, 0);
    op(0, 1, 0, 0, 0, "R10 stack unchanged after push+pop");
    op(0, 1, 0, 0, 0, "R9 pop while empty");
    drain();
    do_reset();
    // R9 underflow raises err and changes nothing
    load_row(11, -12, 13, -14);
    op(0, 1, 1, 0, 5, "R9 pop while empty sets err");
    send(1, 1, 1, 1, 0, 0);
    // R9 overflow: fill, push again, then unwind
    op(1, 0, 0, 0, 0, "R9 push");
    load_row(21, 22, 23, 24);
    op(1, 0, 0, 0, 0, "R9 push");
    load_row(-31, -32, -33, -34);
    op(1, 0, 0, 0, 0, "R9 push");
    load_row(41, 42, 43, 44);
    op(1, 0, 1, 3, 0, "R9 push while full");
    send(1, 2, 3, 4, 0, 0);
    op(0, 1, 0, 0, 0, "R9 pop after overflow");
    send(1, 2, 3, 4, 0, 0);
    op(0, 1, 0, 0, 0, "R9 pop after overflow");
    send(1, 2, 3, 4, 0, 0);
    op(0, 1, 0, 0, 0, "R9 pop after overflow");
    send(1, 2, 3, 4, 0, 0);
    repeat (30) @(negedge clk);
    chk(err == 1'b1, "R9 err stays set", err, 1);
    drain();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule